// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page structure in memory. When a miss is accepted, it reads the first-level (directory) entry chosen by the top index bits of the linear address. It then reads the second-level (table) entry chosen by the middle index bits. Along the way it checks the present flags and the access rights, and writes back the accessed and dirty flags when they must change. It finishes with one of two results: a one-cycle fill of the translation toward the translation cache, or a one-cycle page-fault report carrying vector 14, an error code and the faulting linear address.

The walker has a single request/response memory port with one access outstanding at a time. A directory base frame input locates the first-level table. Entries use this layout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, and bits 31:12 the frame number. The sequencer is a state machine with seven states:

- IDLE waits for a miss.
- READ_DIR fetches the directory entry.
- WRITE_DIR sets the directory accessed flag.
- READ_TBL fetches the table entry.
- WRITE_TBL sets the table flags.
- FILL delivers the translation.
- FAULT reports the fault.

The transitions are:

- IDLE goes to READ_DIR when a miss arrives.
- READ_DIR goes to FAULT if the entry is not present, to WRITE_DIR if its accessed flag is clear, and to READ_TBL otherwise.
- WRITE_DIR goes to READ_TBL.
- READ_TBL goes to FAULT if the entry is not present or the rights are violated, to WRITE_TBL if a flag must change, and to FILL otherwise.
- WRITE_TBL goes to FILL.
- FILL and FAULT both return to IDLE.

Top module: `page_walker`

## Requirements
- R1: The directory entry is read from address {dir_base, laddr[31:22], 2'b00}. If its bit 0 (present) is 0, the walk stops with a page fault whose P bit is 0, and no table entry is read.
- R2: A present directory entry whose bit 5 (accessed) is 0 is written back once with bit 5 set, before the table read. If bit 5 is already 1, no write occurs. The table entry is then read from {dir_entry[31:12], laddr[21:12], 2'b00}.
- R3: A table entry whose bit 0 is 0 ends the walk with a page fault whose P bit is 0.
- R4: The effective user right is the AND of bit 2 in both entries, and the effective writable right is the AND of bit 1 in both entries. A user-mode access needs the user right. A user-mode write also needs the writable right. Supervisor accesses are never refused. A refusal gives a page fault with P = 1 and no table write-back.
- R5: On success, the table entry is written back with bit 5 set and, for a write, bit 6 set. The write-back is skipped when the value would not change.
- R6: A successful walk raises fill_valid for exactly one cycle, carrying the virtual page number, the table frame number and the effective user and writable rights.
- R7: A fault raises fault_valid for exactly one cycle with fault_vector = 14. The fault_code has bit 0 = P (0 not present, 1 protection), bit 1 = 1 for a write, bit 2 = 1 for a user-mode access, and bits 15:3 = 0.
- R8: fault_addr holds the linear address of the most recent fault, and changes only when a new fault is reported.
- R9: At most one memory request is open at a time. It holds its address, direction and data steady until mem_resp_valid is high, and the access completes in that cycle.
- R10: A miss is accepted only while busy is low. A miss offered while busy is high is ignored and starts no memory traffic.
- R11: After reset, busy, mem_req_valid, fill_valid and fault_valid are 0, and fault_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss offered |
| miss_laddr | input | 32 | Linear address that missed |
| miss_write | input | 1 | Miss is for a write access |
| miss_user | input | 1 | Miss is from user mode |
| busy | output | 1 | Walk in progress; misses are ignored |
| dir_base | input | 20 | Frame number of the directory table |
| mem_req_valid | output | 1 | Memory request open |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_resp_valid | input | 1 | Request completes this cycle |
| mem_resp_rdata | input | 32 | Read data for a completing read |
| fill_valid | output | 1 | Translation fill pulse |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_frame | output | 20 | Physical frame number |
| fill_user | output | 1 | Effective user right |
| fill_writable | output | 1 | Effective writable right |
| fault_valid | output | 1 | Page fault pulse |
| fault_vector | output | 8 | Exception vector (14) |
| fault_code | output | 16 | Fault error code |
| fault_addr | output | 32 | Last faulting linear address |

## Verification
Two of the block's functions can fall in the same cycle: the closing fill pulse and the arrival of a fresh miss from the requester. The bench provokes this by raising miss_valid exactly in the cycle where fill_valid is visible. It then judges the outcome at the memory port: no request may appear in the cycles that follow, and busy must settle low. A second coincidence, a memory response in the very cycle a request opens, is driven with zero response latency. The bench then compares every completed access against a reference walk computed from its own memory image.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_WRITE_DIR,
        ST_READ_TBL,
        ST_WRITE_TBL,
        ST_FILL,
        ST_FAULT
    } walk_state_t;

    localparam int BIT_PRESENT  = 0;
    localparam int BIT_WRITABLE = 1;
    localparam int BIT_USER     = 2;
    localparam int BIT_ACCESSED = 5;
    localparam int BIT_DIRTY    = 6;

    localparam logic [7:0] PF_VECTOR = 8'd14;
endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int LA_W   = 32,
    parameter int OFFS_W = 12
) (
    input  logic [LA_W-OFFS_W-1:0] base_frame,
    input  logic [LA_W-OFFS_W-1:0] dir_frame,
    input  logic [LA_W-OFFS_W-1:0] vpn,
    output logic [LA_W-1:0]        dir_addr,
    output logic [LA_W-1:0]        tbl_addr
);
    localparam int FRAME_W = LA_W - OFFS_W;
    localparam int IDX_W   = FRAME_W / 2;

    // Entries are 4 bytes wide, hence the two zero bits at the bottom.
    assign dir_addr = LA_W'({base_frame, vpn[FRAME_W-1 -: IDX_W], 2'b00});
    assign tbl_addr = LA_W'({dir_frame, vpn[IDX_W-1:0], 2'b00});
endmodule

// File: rtl/pw_rights.sv
module pw_rights #(
    parameter int ENT_W = 32
) (
    input  logic             dir_user,
    input  logic             dir_writable,
    input  logic [ENT_W-1:0] tbl_ent,
    input  logic             is_write,
    input  logic             is_user,
    output logic             eff_user,
    output logic             eff_writable,
    output logic             violation,
    output logic [ENT_W-1:0] tbl_next,
    output logic             tbl_update
);
    import pw_pkg::*;

    assign eff_user     = dir_user & tbl_ent[BIT_USER];
    assign eff_writable = dir_writable & tbl_ent[BIT_WRITABLE];
    // Supervisor accesses are never refused.
    assign violation    = is_user & (~eff_user | (is_write & ~eff_writable));

    always_comb begin
        tbl_next = tbl_ent;
        tbl_next[BIT_ACCESSED] = 1'b1;
        if (is_write) tbl_next[BIT_DIRTY] = 1'b1;
    end

    assign tbl_update = (tbl_next != tbl_ent);
endmodule

// File: rtl/page_walker.sv
module page_walker #(
    parameter int LA_W   = 32,
    parameter int OFFS_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   miss_valid,
    input  logic [LA_W-1:0]        miss_laddr,
    input  logic                   miss_write,
    input  logic                   miss_user,
    output logic                   busy,
    input  logic [LA_W-OFFS_W-1:0] dir_base,
    output logic                   mem_req_valid,
    output logic                   mem_req_write,
    output logic [LA_W-1:0]        mem_req_addr,
    output logic [LA_W-1:0]        mem_req_wdata,
    input  logic                   mem_resp_valid,
    input  logic [LA_W-1:0]        mem_resp_rdata,
    output logic                   fill_valid,
    output logic [LA_W-OFFS_W-1:0] fill_vpn,
    output logic [LA_W-OFFS_W-1:0] fill_frame,
    output logic                   fill_user,
    output logic                   fill_writable,
    output logic                   fault_valid,
    output logic [7:0]             fault_vector,
    output logic [15:0]            fault_code,
    output logic [LA_W-1:0]        fault_addr
);
    import pw_pkg::*;

    localparam int FRAME_W = LA_W - OFFS_W;
    localparam int ENT_W   = LA_W;

    walk_state_t        state_q, state_d;
    logic [LA_W-1:0]    laddr_q, fault_addr_q;
    logic [FRAME_W-1:0] base_q;
    logic [ENT_W-1:0]   pde_q, pte_q;
    logic               write_q, user_q, eu_q, ew_q, fault_p_q;

    logic [LA_W-1:0]    dir_addr, tbl_addr;
    logic               eff_user, eff_writable, violation, tbl_update;
    logic [ENT_W-1:0]   tbl_next, pde_marked;

    pw_entry_addr #(.LA_W(LA_W), .OFFS_W(OFFS_W)) u_addr (
        .base_frame (base_q),
        .dir_frame  (pde_q[ENT_W-1:OFFS_W]),
        .vpn        (laddr_q[LA_W-1:OFFS_W]),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr)
    );

    pw_rights #(.ENT_W(ENT_W)) u_rights (
        .dir_user     (pde_q[BIT_USER]),
        .dir_writable (pde_q[BIT_WRITABLE]),
        .tbl_ent      (mem_resp_rdata),
        .is_write     (write_q),
        .is_user      (user_q),
        .eff_user     (eff_user),
        .eff_writable (eff_writable),
        .violation    (violation),
        .tbl_next     (tbl_next),
        .tbl_update   (tbl_update)
    );

    always_comb begin
        pde_marked = pde_q;
        pde_marked[BIT_ACCESSED] = 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (miss_valid) state_d = ST_READ_DIR;
            ST_READ_DIR:  if (mem_resp_valid) begin
                              if (!mem_resp_rdata[BIT_PRESENT])       state_d = ST_FAULT;
                              else if (!mem_resp_rdata[BIT_ACCESSED]) state_d = ST_WRITE_DIR;
                              else                                    state_d = ST_READ_TBL;
                          end
            ST_WRITE_DIR: if (mem_resp_valid) state_d = ST_READ_TBL;
            ST_READ_TBL:  if (mem_resp_valid) begin
                              if (!mem_resp_rdata[BIT_PRESENT] || violation) state_d = ST_FAULT;
                              else if (tbl_update)                          state_d = ST_WRITE_TBL;
                              else                                          state_d = ST_FILL;
                          end
            ST_WRITE_TBL: if (mem_resp_valid) state_d = ST_FILL;
            ST_FILL:      state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Walk context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            laddr_q      <= '0;
            base_q       <= '0;
            write_q      <= 1'b0;
            user_q       <= 1'b0;
            pde_q        <= '0;
            pte_q        <= '0;
            eu_q         <= 1'b0;
            ew_q         <= 1'b0;
            fault_p_q    <= 1'b0;
            fault_addr_q <= '0;
        end else if (state_q == ST_IDLE && miss_valid) begin
            laddr_q <= miss_laddr;
            base_q  <= dir_base;
            write_q <= miss_write;
            user_q  <= miss_user;
        end else if (state_q == ST_READ_DIR && mem_resp_valid) begin
            pde_q <= mem_resp_rdata;
            if (!mem_resp_rdata[BIT_PRESENT]) begin
                fault_p_q    <= 1'b0;
                fault_addr_q <= laddr_q;
            end
        end else if (state_q == ST_READ_TBL && mem_resp_valid) begin
            pte_q <= tbl_next;
            eu_q  <= eff_user;
            ew_q  <= eff_writable;
            if (!mem_resp_rdata[BIT_PRESENT]) begin
                fault_p_q    <= 1'b0;
                fault_addr_q <= laddr_q;
            end else if (violation) begin
                fault_p_q    <= 1'b1;
                fault_addr_q <= laddr_q;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = dir_addr;
        mem_req_wdata = '0;
        fill_valid    = 1'b0;
        fault_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_DIR:  mem_req_valid = 1'b1;
            ST_WRITE_DIR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_wdata = pde_marked;
            end
            ST_READ_TBL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
            end
            ST_WRITE_TBL: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = tbl_addr;
                mem_req_wdata = pte_q;
            end
            ST_FILL:  fill_valid  = 1'b1;
            ST_FAULT: fault_valid = 1'b1;
            default: ;
        endcase
    end

    assign busy          = (state_q != ST_IDLE);
    assign fill_vpn      = laddr_q[LA_W-1:OFFS_W];
    assign fill_frame    = pte_q[ENT_W-1:OFFS_W];
    assign fill_user     = eu_q;
    assign fill_writable = ew_q;
    assign fault_vector  = PF_VECTOR;
    assign fault_code    = {13'b0, user_q, write_q, fault_p_q};
    assign fault_addr    = fault_addr_q;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    // R6
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid && !busy);

    // R7
    fault_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> fault_vector == 8'd14 && !fill_valid && !mem_req_valid);

    // R8
    fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(fault_valid) |-> $stable(fault_addr));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !fill_valid && !fault_valid);
endmodule

// File: tb/page_walker_test.sv
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid;
    logic [31:0] miss_laddr;
    logic        miss_write, miss_user, busy;
    logic [19:0] dir_base;
    logic        mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_rdata;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_frame;
    logic        fill_user, fill_writable, fault_valid;
    logic [7:0]  fault_vector;
    logic [15:0] fault_code;
    logic [31:0] fault_addr;

    always #2 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_laddr(miss_laddr),
        .miss_write(miss_write), .miss_user(miss_user), .busy(busy), .dir_base(dir_base),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
        .fill_user(fill_user), .fill_writable(fill_writable), .fault_valid(fault_valid),
        .fault_vector(fault_vector), .fault_code(fault_code), .fault_addr(fault_addr)
    );

    // Behavioural memory: 2048 words, response after lat waiting cycles
    logic [31:0] mem [0:2047];
    int          lat = 0;
    int          wcnt = 0;
    logic        ld_en = 1'b0;
    logic [10:0] ld_idx;
    logic [31:0] ld_val;

    assign mem_resp_valid = mem_req_valid && (wcnt >= lat);
    assign mem_resp_rdata = mem[mem_req_addr[12:2]];

    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_val;
        if (mem_req_valid && mem_resp_valid) begin
            wcnt <= 0;
            if (mem_req_write) mem[mem_req_addr[12:2]] <= mem_req_wdata;
        end else if (mem_req_valid) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference walk: expected accesses and outcome
    bit          exp_w[$];
    logic [31:0] exp_a[$];
    logic [31:0] exp_d[$];
    string       exp_t[$];
    int          exp_kind = 0;   // 0 none, 1 fill, 2 fault
    logic [19:0] exp_frame, exp_vpn;
    logic        exp_u, exp_wr;
    logic [15:0] exp_code;
    logic [31:0] exp_faddr;
    string       exp_tag;
    logic [31:0] last_fault = 32'h0;
    bit          done = 0;
    bit          run_mon = 0;

    task automatic push(input bit w, input logic [31:0] a, input logic [31:0] d, input string t);
        exp_w.push_back(w); exp_a.push_back(a); exp_d.push_back(d); exp_t.push_back(t);
    endtask

    task automatic build_expect(input logic [31:0] la, input bit wr, input bit us);
        logic [31:0] pa, ta, pde, pte, np;
        bit u, w;
        pa  = {dir_base, la[31:22], 2'b00};
        pde = mem[pa[12:2]];
        push(0, pa, 0, "R1");
        exp_vpn = la[31:12];
        if (!pde[0]) begin
            exp_kind = 2; exp_code = {13'b0, us, wr, 1'b0}; exp_tag = "R1";
        end else begin
            if (!pde[5]) push(1, pa, pde | 32'h20, "R2");
            ta  = {pde[31:12], la[21:12], 2'b00};
            pte = mem[ta[12:2]];
            push(0, ta, 0, "R2");
            if (!pte[0]) begin
                exp_kind = 2; exp_code = {13'b0, us, wr, 1'b0}; exp_tag = "R3";
            end else begin
                u = pde[2] & pte[2];
                w = pde[1] & pte[1];
                if (us && (!u || (wr && !w))) begin
                    exp_kind = 2; exp_code = {13'b0, us, wr, 1'b1}; exp_tag = "R4";
                end else begin
                    np = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                    if (np != pte) push(1, ta, np, "R5");
                    exp_kind = 1; exp_frame = pte[31:12]; exp_u = u; exp_wr = w; exp_tag = "R6";
                end
            end
        end
        if (exp_kind == 2) begin
            exp_faddr  = la;
            last_fault = la;
        end
    endtask

    // Per-cycle comparison against the reference
    bit          prev_wait = 0;
    logic [31:0] prev_addr;
    always @(negedge clk) begin
        if (run_mon) begin
            int k;
            k = exp_kind;
            if (prev_wait)
                chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "held request address",
                    mem_req_addr, prev_addr);
            if (mem_req_valid) begin
                if (exp_a.size() == 0)
                    chk(0, "R10", "unexpected memory request", mem_req_addr, 32'h0);
                else if (mem_resp_valid) begin
                    chk(mem_req_write == exp_w[0], exp_t[0], "access direction",
                        {31'b0, mem_req_write}, {31'b0, exp_w[0]});
                    chk(mem_req_addr == exp_a[0], exp_t[0], "access address", mem_req_addr, exp_a[0]);
                    if (exp_w[0])
                        chk(mem_req_wdata == exp_d[0], exp_t[0], "write-back data",
                            mem_req_wdata, exp_d[0]);
                    void'(exp_w.pop_front()); void'(exp_a.pop_front());
                    void'(exp_d.pop_front()); void'(exp_t.pop_front());
                end
            end
            prev_wait = mem_req_valid && !mem_resp_valid;
            prev_addr = mem_req_addr;
            if (fill_valid) begin
                chk(k == 1, "R6", "fill outcome kind", 32'd1, k);
                if (k == 1) begin
                    chk(fill_frame == exp_frame && fill_vpn == exp_vpn, "R6", "fill frame/vpn",
                        {fill_vpn[11:0], fill_frame}, {exp_vpn[11:0], exp_frame});
                    chk(fill_user == exp_u && fill_writable == exp_wr, "R4", "fill rights",
                        {30'b0, fill_user, fill_writable}, {30'b0, exp_u, exp_wr});
                    chk(exp_a.size() == 0, "R5", "accesses left at fill", exp_a.size(), 0);
                end
                exp_kind = 0; done = 1;
            end
            if (fault_valid) begin
                chk(k == 2, "R7", "fault outcome kind", 32'd2, k);
                if (k == 2) begin
                    chk(fault_code == exp_code, exp_tag, "fault code R7", fault_code, exp_code);
                    chk(fault_vector == 8'd14, "R7", "fault vector", fault_vector, 32'd14);
                    chk(fault_addr == exp_faddr, "R8", "fault address", fault_addr, exp_faddr);
                    chk(exp_a.size() == 0, exp_tag, "accesses left at fault", exp_a.size(), 0);
                end
                exp_kind = 0; done = 1;
            end
        end
    end

    task automatic poke(input logic [31:0] addr, input logic [31:0] val);
        @(negedge clk);
        ld_idx = addr[12:2]; ld_val = val; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic walk(input logic [31:0] la, input bit wr, input bit us, input int l,
                        input bit inject);
        @(negedge clk);
        lat = l;
        build_expect(la, wr, us);
        done = 0;
        miss_laddr = la; miss_write = wr; miss_user = us; miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        if (inject) begin
            while (!fill_valid && !fault_valid) @(negedge clk);
            // new miss lands in the same cycle as the result pulse
            miss_laddr = 32'h0000_0000; miss_write = 1'b0; miss_user = 1'b1; miss_valid = 1'b1;
            @(negedge clk);
            miss_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk(!busy && !mem_req_valid, "R10", "miss during busy ignored",
                {30'b0, busy, mem_req_valid}, 32'h0);
        end else begin
            while (!done) @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; miss_valid = 1'b0; miss_laddr = '0; miss_write = 1'b0; miss_user = 1'b0;
        dir_base = 20'h00000;
        // Directory at frame 0, one table at frame 1
        poke(32'h0000_0000, 32'h0000_0000);   // dir 0: not present
        poke(32'h0000_0004, 32'h0000_1007);   // dir 1: P RW US, A clear
        poke(32'h0000_0008, 32'h0000_1027);   // dir 2: P RW US A
        poke(32'h0000_000C, 32'h0000_1025);   // dir 3: P US A, read-only
        poke(32'h0000_1000, 32'h0000_0000);   // tbl 0: not present
        poke(32'h0000_1004, 32'hABCD_E027);   // tbl 1: P RW US A
        poke(32'h0000_1008, 32'h1234_5003);   // tbl 2: P RW, supervisor, A clear
        poke(32'h0000_100C, 32'h5555_5027);   // tbl 3: P RW US A, D clear
        @(negedge clk);
        // R11 reset state
        chk(!busy && !mem_req_valid && !fill_valid && !fault_valid, "R11", "outputs in reset",
            {28'b0, busy, mem_req_valid, fill_valid, fault_valid}, 32'h0);
        chk(fault_addr == 32'h0, "R11", "fault address in reset", fault_addr, 32'h0);
        rst_n = 1'b1;
        run_mon = 1;
        @(negedge clk);
        chk(!busy && !mem_req_valid, "R11", "idle after reset", {30'b0, busy, mem_req_valid}, 0);

        walk(32'h0000_0123, 0, 1, 0, 0);  // R1 directory not present
        walk(32'h0040_0010, 1, 0, 1, 0);  // R2 dir A set, R3 table not present
        walk(32'h0080_1000, 0, 0, 2, 0);  // R6 fill, no write-backs
        walk(32'h0080_3456, 1, 1, 3, 0);  // R5 dirty write-back
        walk(32'h0080_2000, 0, 1, 1, 0);  // R4 user on supervisor page
        walk(32'h00C0_1000, 1, 1, 0, 0);  // R4 user write on read-only
        walk(32'h00C0_1000, 1, 0, 2, 0);  // R4 supervisor write allowed, R5 dirty
        chk(fault_addr == 32'h00C0_1000, "R8", "fault address held after fill",
            fault_addr, 32'h00C0_1000);
        walk(32'h0080_3456, 1, 1, 0, 1);  // R5 no write-back, R10 miss during fill
        walk(32'h0080_2000, 0, 0, 0, 0);  // R5 accessed write-back, zero latency
        chk(fault_addr == last_fault, "R8", "fault address held", fault_addr, last_fault);
        walk(32'h0000_0FFF, 1, 0, 3, 0);  // R1 again, new fault address
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule